// File: doc/BRIEF.md
# Vectored Interrupt Arbiter

This block gathers interrupt events from 24 sources, keeps a pending flag for each source that needs one, and filters the maskable sources through a global master enable and per-source enables. From the eligible requests it selects the source with the lowest index. It presents that source's identifier and 16-bit handler address to the processor on registered outputs.

The processor takes the interrupt by pulsing an acknowledge while the request output is high. The acknowledge clears the pending flag of the presented source and turns the master enable off. After that, only the non-maskable group can interrupt until software turns the master enable back on. Software can also drop pending flags by writing zeros through a mask port.

Sources are numbered 0 to 23:
- Sources 0 and 1 are driven directly as levels by the instruction decoder and have no pending flag.
- Sources 2 and 3 are latched and non-maskable.
- Sources 4 to 23 are latched and maskable. Source 4 is an external line with an additional pin enable.

Top module: `vec_intc`

## Requirements
- R1: After reset, `irq_o` is 0, `id_o` and `vec_o` are 0, the master enable, pin enable and all per-source enables are 0, and every pending flag is 0.
- R2: A one-cycle pulse on `req_i[k]` for k in 2..23 sets the pending flag of source k. The flag stays set until it is acknowledged or cleared by software. If the source is eligible, `irq_o`, `id_o` and `vec_o` show it at the second rising edge after the pulse cycle.
- R3: Sources 0 and 1 are level requests without a pending flag. They appear at the first rising edge after being raised, and they leave no trace once dropped.
- R4: Sources 0 to 3 are non-maskable. They are presented regardless of the master enable, the pin enable and the `en_wd` flags.
- R5: A source k in 4..23 is presented only while the master enable is 1 and per-source enable bit `en_wd[k-4]` (written with `en_we`) is 1. A masked pending flag is kept, and it is presented once the source is enabled.
- R6: Source 4 additionally requires the pin enable (written with `pin_we`/`pin_wd`) to be 1.
- R7: When several eligible requests are pending, the lowest source index wins.
- R8: The handler address is FFFC for sources 0 and 1, and FFFA−2·(k−2) for k in 2..15. For k in 16..23 it is FFBE−2·(k−16).
- R9: `ack_i` high while `irq_o` is high has three effects at the next edge: it clears the pending flag of source `id_o`, forces `irq_o` to 0, and clears the master enable. The acknowledge overrides a master-enable write in the same cycle. The next winner appears one edge later.
- R10: `ack_i` while `irq_o` is low has no effect.
- R11: A request pulse on a source in the same cycle as that source's acknowledge leaves its pending flag set.
- R12: A write with `lat_we` applies `lat_wd[k-2]` to source k. A 0 clears the pending flag and a 1 leaves it unchanged.
- R13: While no request, write or acknowledge arrives for two cycles running, `irq_o`, `id_o` and `vec_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 24 | Request per source: levels for 0..1, pulses for 2..23 |
| en_we | input | 1 | Write strobe for the per-source enables |
| en_wd | input | 20 | Enable for source k at bit k-4 |
| mie_we | input | 1 | Write strobe for the master enable |
| mie_wd | input | 1 | Master enable value |
| pin_we | input | 1 | Write strobe for the source-4 pin enable |
| pin_wd | input | 1 | Pin enable value |
| lat_we | input | 1 | Write strobe for the pending-flag clear mask |
| lat_wd | input | 22 | Keep mask for source k at bit k-2 (0 clears) |
| ack_i | input | 1 | Interrupt acknowledge |
| irq_o | output | 1 | Interrupt request to the processor |
| id_o | output | 5 | Index of the presented source |
| vec_o | output | 16 | Handler address of the presented source |

## Verification
Two pairs of operations can land in the same clock cycle. The first pair is an acknowledge and a fresh request pulse on the very source being acknowledged. The second pair is an acknowledge and a software write that turns the master enable on. The bench drives both operations of each pair on the same falling edge. It judges the first pair by showing that the source is presented again once the master enable is restored. It judges the second pair by showing that a later maskable request stays unpresented, because the master enable remained off.

// File: rtl/vec_intc.sv
module vec_intc #(
  parameter int NSRC = 24,
  parameter int NDIR = 2,
  parameter int NNMI = 4,
  parameter int PIN_SRC = 4,
  parameter int NHI = 8,
  localparam int IW = $clog2(NSRC),
  localparam int NLAT = NSRC - NDIR,
  localparam int NMSK = NSRC - NNMI
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] req_i,
  input  logic            en_we,
  input  logic [NMSK-1:0] en_wd,
  input  logic            mie_we,
  input  logic            mie_wd,
  input  logic            pin_we,
  input  logic            pin_wd,
  input  logic            lat_we,
  input  logic [NLAT-1:0] lat_wd,
  input  logic            ack_i,
  output logic            irq_o,
  output logic [IW-1:0]   id_o,
  output logic [15:0]     vec_o
);

  logic [NLAT-1:0] lat_q, ack_clr, lat_n;
  logic [NMSK-1:0] en_q;
  logic            mie_q, pin_q;
  logic [NSRC-1:0] pend, elig;
  logic [IW-1:0]   win;
  logic            ack_hit;

  function automatic logic [15:0] vec_of(input int k);
    if (k < NDIR)             return 16'hFFFC;
    else if (k < NSRC - NHI)  return 16'(32'hFFFA - 2 * (k - NDIR));
    else                      return 16'(32'hFFBE - 2 * (k - (NSRC - NHI)));
  endfunction

  assign pend    = {lat_q, req_i[NDIR-1:0]};
  assign ack_hit = ack_i & irq_o;

  for (genvar i = 0; i < NSRC; i++) begin : g_elig
    if (i < NNMI) begin : g_nmi
      assign elig[i] = pend[i];
    end else if (i == PIN_SRC) begin : g_pin
      assign elig[i] = pend[i] & mie_q & en_q[i-NNMI] & pin_q;
    end else begin : g_msk
      assign elig[i] = pend[i] & mie_q & en_q[i-NNMI];
    end
  end

  for (genvar k = 0; k < NLAT; k++) begin : g_clr
    assign ack_clr[k] = ack_hit && (id_o == IW'(k + NDIR));
  end

  assign lat_n = ((lat_we ? (lat_q & lat_wd) : lat_q) & ~ack_clr) | req_i[NSRC-1:NDIR];

  always_comb begin
    win = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (elig[i]) win = IW'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
      en_q  <= '0;
      mie_q <= 1'b0;
      pin_q <= 1'b0;
      irq_o <= 1'b0;
      id_o  <= '0;
      vec_o <= '0;
    end else begin
      lat_q <= lat_n;
      if (en_we)  en_q  <= en_wd;
      if (pin_we) pin_q <= pin_wd;
      if (ack_hit)     mie_q <= 1'b0;
      else if (mie_we) mie_q <= mie_wd;
      if (ack_hit) begin
        irq_o <= 1'b0;
      end else begin
        irq_o <= |elig;
        if (|elig) begin
          id_o  <= win;
          vec_o <= vec_of(int'(win));
        end
      end
    end
  end

endmodule

// File: rtl/vec_intc_chk.sv
module vec_intc_chk #(
  parameter int NSRC = 24,
  parameter int NDIR = 2,
  parameter int NNMI = 4,
  localparam int IW = $clog2(NSRC),
  localparam int NLAT = NSRC - NDIR
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] req_i,
  input logic            en_we,
  input logic            mie_we,
  input logic            pin_we,
  input logic            lat_we,
  input logic            ack_i,
  input logic            irq_o,
  input logic [IW-1:0]   id_o,
  input logic [15:0]     vec_o,
  input logic            mie_q,
  input logic [NLAT-1:0] lat_q
);

  logic quiet, quiet_d;
  assign quiet = (req_i == '0) && !en_we && !mie_we && !pin_we && !lat_we && !ack_i;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) quiet_d <= 1'b0;
    else        quiet_d <= quiet;

  AST_ACK_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i && irq_o |=> !irq_o); // R9
  AST_ACK_CLEARS_MIE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i && irq_o |=> !mie_q); // R9
  AST_MASK_NEEDS_MIE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o && (id_o >= IW'(NNMI)) |-> $past(mie_q)); // R5
  AST_REQ_SETS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i[NSRC-1:NDIR] != '0) |=>
      ((lat_q & $past(req_i[NSRC-1:NDIR])) == $past(req_i[NSRC-1:NDIR]))); // R11
  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    quiet && quiet_d |=> $stable(irq_o) && $stable(id_o) && $stable(vec_o)); // R13

endmodule

bind vec_intc vec_intc_chk #(.NSRC(NSRC), .NDIR(NDIR), .NNMI(NNMI)) chk (.*);

// File: tb/vec_intc_test.sv
`timescale 1ns/1ps
module vec_intc_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] req_i = '0;
  logic        en_we = 1'b0, mie_we = 1'b0, mie_wd = 1'b0;
  logic        pin_we = 1'b0, pin_wd = 1'b0, lat_we = 1'b0, ack_i = 1'b0;
  logic [19:0] en_wd = '0;
  logic [21:0] lat_wd = '0;
  logic        irq_o;
  logic [4:0]  id_o;
  logic [15:0] vec_o;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  vec_intc uut (.*);

  function automatic int vexp(input int k);
    if (k < 2)       return 'hFFFC;
    else if (k < 16) return 'hFFFA - 2 * (k - 2);
    else             return 'hFFBE - 2 * (k - 16);
  endfunction

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(input string rq, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic expect_out(input string rq, input bit e_irq, input int e_id);
    chk({rq, " irq"}, int'(irq_o), int'(e_irq));
    if (e_irq) begin
      chk({rq, " id"}, int'(id_o), e_id);
      chk({rq, " vec R8"}, int'(vec_o), vexp(e_id));
    end
  endtask

  task automatic pulse(input logic [23:0] m);
    req_i = m; tick(); req_i = '0;
  endtask
  task automatic do_ack();
    ack_i = 1'b1; tick(); ack_i = 1'b0;
  endtask
  task automatic wr_mie(input bit v);
    mie_we = 1'b1; mie_wd = v; tick(); mie_we = 1'b0;
  endtask
  task automatic wr_en(input logic [19:0] v);
    en_we = 1'b1; en_wd = v; tick(); en_we = 1'b0;
  endtask
  task automatic wr_pin(input bit v);
    pin_we = 1'b1; pin_wd = v; tick(); pin_we = 1'b0;
  endtask
  task automatic wr_lat(input logic [23:0] keep);
    lat_we = 1'b1; lat_wd = keep[23:2]; tick(); lat_we = 1'b0;
  endtask

  initial begin
    #(20.0 * 200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq", int'(irq_o), 0);
    chk("R1 id", int'(id_o), 0);
    chk("R1 vec", int'(vec_o), 0);
    pulse(24'(1) << 10); tick();
    expect_out("R1/R5 masked at reset", 0, 0);
    wr_lat('0);

    wr_en('1); wr_pin(1);

    for (int k = 2; k < 24; k++) begin
      wr_mie(1);
      pulse(24'(1) << k);
      expect_out("R2 latency", 0, 0);
      tick();
      expect_out("R2 single", 1, k);
      do_ack();
      expect_out("R9 drop", 0, 0);
      wr_mie(1); tick();
      expect_out("R9 latch cleared", 0, 0);
    end

    for (int k = 0; k < 2; k++) begin
      req_i = 24'(1) << k; tick();
      expect_out("R3 direct", 1, k);
      ack_i = 1'b1; req_i = '0; tick(); ack_i = 1'b0;
      expect_out("R3 ack", 0, 0);
      tick();
      expect_out("R3 no latch", 0, 0);
    end

    wr_mie(0);
    pulse(24'(1) << 2); tick();
    expect_out("R4 nmi no mie", 1, 2);
    do_ack();
    wr_en('0);
    pulse(24'(1) << 3); tick();
    expect_out("R4 nmi no en", 1, 3);
    do_ack();
    wr_mie(1);
    pulse(24'(1) << 7); tick();
    expect_out("R5 en off", 0, 0);
    wr_en('1); tick();
    expect_out("R5 enabled later", 1, 7);
    do_ack();

    wr_pin(0); wr_mie(1);
    pulse(24'(1) << 4); tick();
    expect_out("R6 pin off", 0, 0);
    wr_pin(1); tick();
    expect_out("R6 pin on", 1, 4);
    do_ack();

    for (int i = 2; i < 24; i++)
      for (int j = i + 1; j < 24; j++) begin
        wr_mie(1);
        pulse((24'(1) << i) | (24'(1) << j)); tick();
        expect_out("R7 pair first", 1, i);
        do_ack(); wr_mie(1); tick();
        expect_out("R7 pair second", 1, j);
        do_ack(); wr_mie(1); tick();
        expect_out("R7 pair empty", 0, 0);
      end

    wr_mie(1);
    pulse(24'(1) << 5);
    req_i = 24'(1); tick();
    expect_out("R7 direct beats latched", 1, 0);
    ack_i = 1'b1; req_i = '0; tick(); ack_i = 1'b0;
    wr_mie(1); tick();
    expect_out("R7 latched after direct", 1, 5);
    do_ack();

    wr_mie(1);
    req_i = 24'(1) << 9; tick(); req_i = '0;
    ack_i = 1'b1; tick(); ack_i = 1'b0;
    expect_out("R10 ack idle ignored", 1, 9);
    do_ack();

    wr_mie(1);
    pulse(24'(1) << 6); tick();
    expect_out("R11 present", 1, 6);
    ack_i = 1'b1; req_i = 24'(1) << 6; tick(); ack_i = 1'b0; req_i = '0;
    expect_out("R11 ack", 0, 0);
    wr_mie(1); tick();
    expect_out("R11 kept", 1, 6);
    do_ack(); wr_mie(1); tick();
    expect_out("R11 drained", 0, 0);

    wr_mie(1);
    pulse(24'(1) << 8); tick();
    expect_out("R9 present", 1, 8);
    ack_i = 1'b1; mie_we = 1'b1; mie_wd = 1'b1; tick();
    ack_i = 1'b0; mie_we = 1'b0;
    pulse(24'(1) << 9); tick(); tick();
    expect_out("R9 ack beats mie write", 0, 0);
    wr_lat('0);

    wr_mie(0);
    pulse((24'(1) << 12) | (24'(1) << 15));
    wr_lat(~(24'(1) << 12));
    wr_mie(1); tick();
    expect_out("R12 zero clears", 1, 15);
    do_ack();
    wr_lat('1); wr_mie(1); tick();
    expect_out("R12 one no effect", 0, 0);

    pulse(24'(1) << 20); tick();
    for (int n = 0; n < 5; n++) begin
      tick();
      expect_out("R13 hold", 1, 20);
    end
    do_ack();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule